// File: doc/BRIEF.md
# XGMII Receive Frame Decoder

This block takes a 64-bit XGMII receive word stream, eight byte lanes with a control flag per lane, and turns it into a 64-bit AXI-Stream frame stream. It waits for a start word, drops the preamble and delimiter, and delivers the frame bytes packed from lane 0. Lane 0 of the first output beat is the first destination-address byte.

A terminate character may arrive in any lane. Its position sets the byte mask of the final beat. The trailing four-byte frame check sequence is checked with CRC-32 and removed before output. Frames that arrive corrupted, that are cut short by an unexpected control character, or that lose a beat because the sink stalled, are flagged with tuser on their last beat. The output has no backpressure path: the sink is expected to keep tready high.

Top module: `xgmii_rx_axis`

## Requirements
- R1: After reset, tvalid, tlast and tuser are low and the decoder waits for a start word.
- R2: A start word is recognised only when the control flags equal 0x01, lane 0 (bits 7:0) holds 0xFB, lanes 1 to 6 hold 0x55 and lane 7 holds 0xD5. Outside a frame, any other word produces no output. This includes a start character in another lane and a start with a damaged preamble. Preamble bytes never appear at the output.
- R3: Frame byte n, received in lane (n mod 8) of the data words that follow the start word, appears in output lane (n mod 8) (tdata bits 8k+7:8k). Beats come out in frame order.
- R4: A terminate word has 0xFD in lane k, control flags set on lanes k to 7 and clear below k, and 0x07 in lanes above k. On such a word the frame ends with exactly one tlast beat. The last 4 received bytes are removed, so a frame carrying L bytes before its check sequence yields L output bytes. The tlast beat has tkeep packed from bit 0 with ((L-1) mod 8)+1 ones.
- R5: The CRC-32 uses reflected polynomial 0xEDB88320 and an all-ones seed. The check sequence is the complement of the CRC, sent low byte first. When it does not match, tuser is 1 on the tlast beat; when it matches, tuser is 0.
- R6: Every beat other than the last has tkeep all ones, tlast 0 and tuser 0.
- R7: Inside a frame, a word with any control flag set that is not a valid terminate word closes the frame. All data words received so far are delivered, the last with tlast and tuser high and tkeep all ones. If no data word was received, nothing is output.
- R8: A frame whose terminate arrives in the first word after the start word produces no output.
- R9: If tready is low while a non-final beat is valid, that frame's tlast beat carries tuser high. The following frame is not affected.
- R10: A start word that follows a terminate word after a single idle word is accepted, whatever the lane of that terminate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for receive data and output |
| rst | input | 1 | Synchronous active-high reset |
| xgmiiRxd | input | 64 | Receive data, lane k in bits 8k+7:8k |
| xgmiiRxc | input | 8 | Receive control flags, bit k for lane k |
| mAxisTdata | output | 64 | Output frame bytes |
| mAxisTkeep | output | 8 | Valid byte mask of the beat |
| mAxisTvalid | output | 1 | Beat valid |
| mAxisTready | input | 1 | Sink ready; low during a beat marks the frame bad |
| mAxisTlast | output | 1 | Final beat of a frame |
| mAxisTuser | output | 1 | Frame error flag, meaningful on the final beat |

## Verification
A corrupted hold register or a wrong lane for the terminate shows up as wrong output bytes or a wrong final tkeep. These appear at most two cycles after the terminate word is sampled. A wrong CRC accumulator flips tuser on the tlast beat of every frame. A control machine left in the wrong state either drops the next frame or sends out bytes that no start word opened. Frame lengths are swept across all eight terminate lanes with both good and damaged check sequences, so each of these faults surfaces at the ports within one frame.

// File: rtl/xgrx_pkg.sv
package xgrx_pkg;
  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_PRE   = 8'h55;
  localparam logic [7:0] CH_SFD   = 8'hD5;

  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  typedef enum logic [1:0] {ST_SEEK, ST_BODY, ST_TAIL} rxState_t;

  // strobes from the control machine to the datapath
  typedef struct packed {
    logic       crcInit;
    logic       crcStep;
    logic       shiftIn;
    logic       emitHeld;
    logic       heldLast;
    logic [7:0] heldCount;
    logic       loadPend;
    logic [7:0] pendCount;
    logic       emitPend;
    logic       checkCrc;
    logic       forceBad;
    logic [7:0] termLane;
  } rxStrobe_t;
endpackage

// File: rtl/xgrx_ctrl.sv
module xgrx_ctrl
  import xgrx_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int FCS_LEN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*8-1:0] rxData,
  input  logic [LANES-1:0]   rxCtrl,
  output rxStrobe_t          strb
);
  localparam int DW = LANES * 8;
  localparam logic [LANES-1:0] ALL_CTRL = '1;

  rxState_t state, stateNext;
  logic haveHeld, haveHeldNext;
  logic isStart, isData, termHit;
  logic [LANES-1:0] termAt;
  logic [7:0] termLane;

  // terminate candidates, one per lane
  for (genvar k = 0; k < LANES; k++) begin : g_term
    logic hit;
    always_comb begin
      hit = (rxCtrl == (ALL_CTRL << k)) && (rxData[8*k +: 8] == CH_TERM);
      for (int j = k + 1; j < LANES; j++)
        if (rxData[8*j +: 8] != CH_IDLE) hit = 1'b0;
    end
    assign termAt[k] = hit;
  end

  always_comb begin
    isData  = (rxCtrl == '0);
    isStart = (rxCtrl == LANES'(1)) && (rxData[7:0] == CH_START) &&
              (rxData[DW-1 -: 8] == CH_SFD);
    for (int l = 1; l < LANES - 1; l++)
      if (rxData[8*l +: 8] != CH_PRE) isStart = 1'b0;
    termHit  = |termAt;
    termLane = '0;
    for (int k = 0; k < LANES; k++)
      if (termAt[k]) termLane = 8'(k);
  end

  always_comb begin
    strb          = '0;
    strb.termLane = termLane;
    stateNext     = state;
    haveHeldNext  = haveHeld;
    case (state)
      ST_SEEK: begin
        if (isStart) begin
          strb.crcInit = 1'b1;
          haveHeldNext = 1'b0;
          stateNext    = ST_BODY;
        end
      end
      ST_BODY: begin
        if (isData) begin
          strb.crcStep = 1'b1;
          strb.shiftIn = 1'b1;
          haveHeldNext = 1'b1;
          if (haveHeld) begin
            strb.emitHeld  = 1'b1;
            strb.heldCount = 8'(LANES);
          end
        end else if (termHit) begin
          stateNext = ST_SEEK;
          if (haveHeld) begin
            strb.emitHeld = 1'b1;
            strb.checkCrc = 1'b1;
            if (termLane > 8'(FCS_LEN)) begin
              strb.heldCount = 8'(LANES);
              strb.loadPend  = 1'b1;
              strb.pendCount = termLane - 8'(FCS_LEN);
              stateNext      = ST_TAIL;
            end else begin
              strb.heldLast  = 1'b1;
              strb.heldCount = 8'(LANES - FCS_LEN) + termLane;
            end
          end
        end else begin
          stateNext = ST_SEEK;
          if (haveHeld) begin
            strb.emitHeld  = 1'b1;
            strb.heldLast  = 1'b1;
            strb.heldCount = 8'(LANES);
            strb.forceBad  = 1'b1;
          end
        end
      end
      ST_TAIL: begin
        strb.emitPend = 1'b1;
        stateNext     = ST_SEEK;
      end
      default: stateNext = ST_SEEK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SEEK;
      haveHeld <= 1'b0;
    end else begin
      state    <= stateNext;
      haveHeld <= haveHeldNext;
    end
  end

  // R2: without exact start flags the decoder stays in search
  p_seek_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEEK && rxCtrl != LANES'(1)) |=> state == ST_SEEK);
  // R7: a stray control word inside a frame returns to search
  p_abort_returns_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BODY && rxCtrl != '0 && termAt == '0) |=> state == ST_SEEK);
  // R10: the tail beat takes one cycle, then search resumes
  p_tail_single_r10: assert property (@(posedge clk) disable iff (rst)
    state == ST_TAIL |=> state == ST_SEEK);
endmodule

// File: rtl/xgrx_dp.sv
module xgrx_dp
  import xgrx_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*8-1:0] rxData,
  input  rxStrobe_t          strb,
  input  logic               tready,
  output logic [LANES*8-1:0] tdata,
  output logic [LANES-1:0]   tkeep,
  output logic               tvalid,
  output logic               tlast,
  output logic               tuser
);
  localparam int DW = LANES * 8;

  function automatic logic [31:0] crcFold(input logic [31:0] seed,
                                          input logic [DW-1:0] d,
                                          input logic [7:0] n);
    logic [31:0] c;
    c = seed;
    for (int b = 0; b < LANES; b++) begin
      if (8'(b) < n) begin
        c = c ^ {24'h0, d[8*b +: 8]};
        for (int i = 0; i < 8; i++)
          c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
      end
    end
    return c;
  endfunction

  function automatic logic [LANES-1:0] keepOf(input logic [7:0] n);
    logic [LANES-1:0] m;
    for (int b = 0; b < LANES; b++) m[b] = (8'(b) < n);
    return m;
  endfunction

  logic [31:0]      crcAcc, crcEnd;
  logic [DW-1:0]    heldData, pendData, oData;
  logic [LANES-1:0] pendKeep, oKeep;
  logic             pendBad, lostSticky, oValid, oLast, oUser;
  logic             crcBad, stallNow;

  assign crcEnd   = crcFold(crcAcc, rxData, strb.termLane);
  assign crcBad   = (crcEnd != CRC_RESIDUE);
  assign stallNow = oValid & ~tready & ~oLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      crcAcc     <= CRC_SEED;
      heldData   <= '0;
      pendData   <= '0;
      pendKeep   <= '0;
      pendBad    <= 1'b0;
      lostSticky <= 1'b0;
      oData      <= '0;
      oKeep      <= '0;
      oValid     <= 1'b0;
      oLast      <= 1'b0;
      oUser      <= 1'b0;
    end else begin
      if (strb.crcInit)      crcAcc <= CRC_SEED;
      else if (strb.crcStep) crcAcc <= crcFold(crcAcc, rxData, 8'(LANES));
      if (strb.shiftIn) heldData <= rxData;
      if (strb.loadPend) begin
        pendData <= rxData;
        pendKeep <= keepOf(strb.pendCount);
        pendBad  <= strb.checkCrc & crcBad;
      end
      if (strb.crcInit)  lostSticky <= 1'b0;
      else if (stallNow) lostSticky <= 1'b1;
      oValid <= strb.emitHeld | strb.emitPend;
      if (strb.emitHeld) begin
        oData <= heldData;
        oKeep <= keepOf(strb.heldCount);
        oLast <= strb.heldLast;
        oUser <= strb.heldLast & (strb.forceBad | (strb.checkCrc & crcBad) |
                                  lostSticky | stallNow);
      end else if (strb.emitPend) begin
        oData <= pendData;
        oKeep <= pendKeep;
        oLast <= 1'b1;
        oUser <= pendBad | lostSticky | stallNow;
      end else begin
        oKeep <= '0;
        oLast <= 1'b0;
        oUser <= 1'b0;
      end
    end
  end

  assign tdata  = oData;
  assign tkeep  = oKeep;
  assign tvalid = oValid;
  assign tlast  = oLast;
  assign tuser  = oUser;

  // R1: nothing valid in the first cycle out of reset
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tvalid);
  // R4: the valid mask is nonzero and packed from lane 0
  p_keep_packed_r4: assert property (@(posedge clk) disable iff (rst)
    tvalid |-> (tkeep != '0) && (((tkeep + 1'b1) & tkeep) == '0));
  // R4: the tail beat is always the last of its frame
  p_tail_beat_last_r4: assert property (@(posedge clk) disable iff (rst)
    strb.emitPend |=> (tvalid && tlast));
  // R6: beats before the last are full and clean
  p_mid_full_r6: assert property (@(posedge clk) disable iff (rst)
    (tvalid && !tlast) |-> (tkeep == '1 && !tuser));
  // R5: the error flag appears only on a final beat
  p_user_on_last_r5: assert property (@(posedge clk) disable iff (rst)
    tuser |-> (tvalid && tlast));
  // R7: an aborted frame ends flagged
  p_abort_flagged_r7: assert property (@(posedge clk) disable iff (rst)
    strb.forceBad |=> (tvalid && tlast && tuser));
endmodule

// File: rtl/xgmii_rx_axis.sv
module xgmii_rx_axis
  import xgrx_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int FCS_LEN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*8-1:0] xgmiiRxd,
  input  logic [LANES-1:0]   xgmiiRxc,
  output logic [LANES*8-1:0] mAxisTdata,
  output logic [LANES-1:0]   mAxisTkeep,
  output logic               mAxisTvalid,
  input  logic               mAxisTready,
  output logic               mAxisTlast,
  output logic               mAxisTuser
);
  rxStrobe_t strb;

  xgrx_ctrl #(.LANES(LANES), .FCS_LEN(FCS_LEN)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .rxData (xgmiiRxd),
    .rxCtrl (xgmiiRxc),
    .strb   (strb)
  );

  xgrx_dp #(.LANES(LANES)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .rxData (xgmiiRxd),
    .strb   (strb),
    .tready (mAxisTready),
    .tdata  (mAxisTdata),
    .tkeep  (mAxisTkeep),
    .tvalid (mAxisTvalid),
    .tlast  (mAxisTlast),
    .tuser  (mAxisTuser)
  );
endmodule

// File: tb/sim_xgmii_rx_axis.sv
`timescale 1ns/1ps
module sim_xgmii_rx_axis;
  localparam logic [63:0] IDLE_W  = 64'h0707070707070707;
  localparam logic [63:0] START_W = 64'hD5555555555555FB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] rxd = IDLE_W;
  logic [7:0]  rxc = 8'hFF;
  logic        tready = 1'b1;
  wire  [63:0] tdata;
  wire  [7:0]  tkeep;
  wire         tvalid, tlast, tuser;

  always #2 clk = ~clk;

  xgmii_rx_axis u0 (
    .clk(clk), .rst(rst), .xgmiiRxd(rxd), .xgmiiRxc(rxc),
    .mAxisTdata(tdata), .mAxisTkeep(tkeep), .mAxisTvalid(tvalid),
    .mAxisTready(tready), .mAxisTlast(tlast), .mAxisTuser(tuser)
  );

  int vecs = 0, errs = 0;

  // output monitor
  logic [7:0] cap [0:255];
  int         capLen = 0, lastCnt = 0, midBad = 0;
  logic       lastUser = 1'b0;
  logic [7:0] lastKeep = 8'h00;
  always @(negedge clk) begin
    if (!rst && tvalid) begin
      for (int b = 0; b < 8; b++)
        if (tkeep[b]) begin
          cap[capLen % 256] = tdata[8*b +: 8];
          capLen++;
        end
      if (!tlast && (tkeep != 8'hFF || tuser)) midBad++;
      if (tlast) begin
        lastCnt++;
        lastUser = tuser;
        lastKeep = tkeep;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R1 watchdog expired: actual hung, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs + 1, errs + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int i, int seed);
    return 8'((i * 29 + seed * 11 + 5) % 256);
  endfunction

  logic [7:0] fb [0:63];

  // bitwise reference CRC over fb[0..n-1], returned complemented
  function automatic logic [31:0] refFcs(int n);
    logic [31:0] c;
    logic fbit;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        fbit = fb[i][k] ^ c[0];
        c = (c >> 1) ^ (fbit ? 32'hEDB88320 : 32'h0);
      end
    return ~c;
  endfunction

  task automatic buildFrame(int len, int seed);
    logic [31:0] f;
    for (int i = 0; i < len; i++) fb[i] = pat(i, seed);
    f = refFcs(len);
    for (int j = 0; j < 4; j++) fb[len + j] = f[8*j +: 8];
  endtask

  task automatic putWord(logic [63:0] d, logic [7:0] c);
    rxd = d;
    rxc = c;
    @(posedge clk);
    #1;
  endtask

  task automatic idles(int n);
    for (int i = 0; i < n; i++) putWord(IDLE_W, 8'hFF);
  endtask

  function automatic logic [63:0] dataWord(int base);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[8*b +: 8] = fb[base + b];
    return w;
  endfunction

  task automatic sendBody(int total, int stallWord);
    logic [63:0] w;
    logic [7:0]  c;
    int i, n, rem;
    i = 0;
    n = 0;
    putWord(START_W, 8'h01);
    while (total - i >= 8) begin
      tready = (n != stallWord);
      putWord(dataWord(i), 8'h00);
      i += 8;
      n++;
    end
    tready = 1'b1;
    rem = total - i;
    w = IDLE_W;
    c = 8'hFF;
    for (int b = 0; b < rem; b++) begin
      w[8*b +: 8] = fb[i + b];
      c[b] = 1'b0;
    end
    w[8*rem +: 8] = 8'hFD;
    putWord(w, c);
  endtask

  function automatic logic [7:0] expKeep(int len);
    int r;
    r = len % 8;
    return (r == 0) ? 8'hFF : 8'((1 << r) - 1);
  endfunction

  task automatic checkBytes(int base, int len, int seed, string req);
    int bad;
    bad = -1;
    for (int i = 0; i < len; i++)
      if (bad < 0 && cap[(base + i) % 256] != pat(i, seed)) bad = i;
    check(bad < 0, req, "byte order/content",
          (bad < 0) ? 0 : cap[(base + bad) % 256], (bad < 0) ? 0 : pat(bad, seed));
  endtask

  task automatic runFrame(int len, bit bad, int stallWord);
    int base, lc, mb;
    buildFrame(len, len);
    if (bad) fb[len] = fb[len] ^ 8'h81;
    base = capLen;
    lc = lastCnt;
    mb = midBad;
    sendBody(len + 4, stallWord);
    idles(3);
    check(capLen - base == len, "R4", "output byte count", capLen - base, len);
    checkBytes(base, len, len, "R3");
    check(lastCnt - lc == 1, "R4", "tlast beats", lastCnt - lc, 1);
    check(lastKeep == expKeep(len), "R4", "final tkeep", lastKeep, expKeep(len));
    if (stallWord >= 0)
      check(lastUser == 1'b1, "R9", "tuser after stall", lastUser, 1);
    else
      check(lastUser == bad, "R5", "tuser vs CRC", lastUser, bad);
    check(midBad == mb, "R6", "non-final beat shape", midBad - mb, 0);
  endtask

  // start, nWords data words, then one offending control word
  task automatic runAbort(int nWords, logic [63:0] badW, logic [7:0] badC, string req);
    int base, lc;
    buildFrame(40, 7);
    base = capLen;
    lc = lastCnt;
    putWord(START_W, 8'h01);
    for (int n = 0; n < nWords; n++) putWord(dataWord(8 * n), 8'h00);
    putWord(badW, badC);
    idles(3);
    check(capLen - base == 8 * nWords, req, "aborted byte count", capLen - base, 8 * nWords);
    if (nWords > 0) begin
      checkBytes(base, 8 * nWords, 7, req);
      check(lastCnt - lc == 1 && lastUser && lastKeep == 8'hFF, req,
            "abort final beat", {lastCnt - lc, 3'b0, lastUser, lastKeep}, {32'd1, 4'd1, 8'hFF});
    end else begin
      check(lastCnt == lc, req, "no beat for empty abort", lastCnt - lc, 0);
    end
  endtask

  task automatic expectNothing(int base, int lc, string req, string what);
    check(capLen == base && lastCnt == lc, req, what, capLen - base, 0);
  endtask

  initial begin
    int base, lc;
    logic [63:0] w;
    #1;
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!tvalid && !tlast && !tuser, "R1", "outputs after reset",
          {tvalid, tlast, tuser}, 0);
    @(posedge clk);
    #1;
    idles(2);

    // R2: words that are not an exact start are ignored
    base = capLen; lc = lastCnt;
    buildFrame(20, 3);
    putWord(64'h55555555555555FB, 8'h01);
    putWord(dataWord(0), 8'h00);
    putWord(dataWord(8), 8'h00);
    putWord({24'h0707FD, dataWord(16)[39:0]}, 8'hE0);
    idles(3);
    expectNothing(base, lc, "R2", "damaged preamble ignored");
    base = capLen; lc = lastCnt;
    putWord(64'hD55555FB07070707, 8'h10);
    putWord(dataWord(0), 8'h00);
    putWord(dataWord(8), 8'h00);
    putWord(64'h07070707070707FD, 8'hFF);
    idles(3);
    expectNothing(base, lc, "R2", "start in lane 4 ignored");

    // R3 R4 R5 R6: sweep of lengths covering every terminate lane
    for (int len = 5; len <= 36; len++) begin
      runFrame(len, 1'b0, -1);
      runFrame(len, 1'b1, -1);
    end

    // R8: terminate directly after the start word
    base = capLen; lc = lastCnt;
    buildFrame(1, 2);
    sendBody(5, -1);
    idles(3);
    expectNothing(base, lc, "R8", "runt with terminate in lane 5");
    base = capLen; lc = lastCnt;
    putWord(START_W, 8'h01);
    putWord(IDLE_W & 64'hFFFFFFFFFFFFFF00 | 64'hFD, 8'hFF);
    idles(3);
    expectNothing(base, lc, "R8", "runt with terminate in lane 0");

    // R7: stray control characters inside a frame
    w = IDLE_W;
    w[39:32] = 8'hFB;
    runAbort(3, w, 8'h10, "R7");
    w = dataWord(0);
    w[23:16] = 8'hFE;
    runAbort(2, w, 8'h04, "R7");
    runAbort(1, 64'h0707070707FD0000, 8'h04, "R7");
    runAbort(0, 64'h07070707070707FE, 8'hFF, "R7");

    // R9: stall on a middle beat flags the frame, next frame is clean
    runFrame(36, 1'b0, 3);
    runFrame(36, 1'b0, -1);

    // R10: single idle word between frames, tail-beat terminate first
    base = capLen; lc = lastCnt;
    buildFrame(35, 35);
    sendBody(39, -1);
    idles(1);
    buildFrame(20, 20);
    sendBody(24, -1);
    idles(4);
    check(capLen - base == 55 && lastCnt - lc == 2, "R10", "back-to-back byte count",
          capLen - base, 55);
    checkBytes(base, 35, 35, "R10");
    checkBytes(base + 35, 20, 20, "R10");
    check(lastUser == 1'b0 && lastKeep == 8'h0F, "R10", "second frame end",
          {lastUser, lastKeep}, 8'h0F);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule